// File: doc/BRIEF.md
# Multi-drop packet receive port (PHY side)

This block is one port on a shared, byte-wide packet receive bus. It keeps a small byte buffer that a local producer fills through a simple write interface. Each byte carries a start tag, an end tag and a bad-packet tag. A link-layer master shares one address bus, one enable and one data bus among many such ports. It polls ports by address to learn which of them has something to deliver, and then it selects one port to stream a packet.

A poll of the port's own address is answered on the next clock with a packet-available flag. The port drives that flag only in the cycle that follows its own address. A selection starts when the master raises the enable while presenting the port's address. The port then drives valid, data, start, end and error. It ends each selection after one packet. It releases its drivers to high impedance on the first edge that samples the enable low. The master may poll any address while a selection lasts, so this port answers its polls even while another port owns the data bus. Address 5'h1F is reserved as the null address, and no port ever matches it.

Top module: `pkt_rx_port`

## Requirements
- R1: The edge that samples `bus_addr` equal to `my_addr` makes `pkt_avail` driven with the availability state for one cycle. Every other cycle leaves it at high impedance. This holds whatever `bus_en` is and whichever port owns the data bus.
- R2: The port reports a packet as available (`pkt_avail` = 1) when at least one buffered byte carries the end tag, or when at least `BLOCK_BYTES` bytes are buffered. Otherwise it reports 0.
- R3: When `my_addr` is 5'h1F, the port never answers a poll and never becomes selected.
- R4: A selection starts on the edge that samples `bus_en` high, `bus_addr` equal to `my_addr`, and `bus_en` low on the previous edge. From that edge the data-bus outputs are driven. If the buffer holds a byte, the port asserts `rx_valid` with the oldest byte, and `rx_sop` equals that byte's start tag.
- R5: While the port is selected and bytes remain, it presents one byte per cycle in write order with `rx_valid` high. `rx_sop` is high only on a byte written with the start tag. If the buffer runs empty, `rx_valid` is low, `rx_data` is 0, and the outputs stay driven.
- R6: The byte written with the end tag appears with `rx_eop` high. On the next edge `rx_valid` and `rx_eop` go low. No further byte is sent in the same selection, even if more bytes are buffered.
- R7: `rx_err` is high only together with `rx_eop`, and only when the end byte was written with the bad tag.
- R8: Once selected, the port stays selected while `bus_en` stays high, whatever `bus_addr` does. The edge that samples `bus_en` low releases `rx_valid`, `rx_data`, `rx_sop`, `rx_eop` and `rx_err` to high impedance.
- R9: If the enable drops in the middle of a packet, the next selection resumes with the following byte, and `rx_sop` stays low.
- R10: `wr_ready` is high while fewer than `DEPTH` bytes are buffered. A write offered while it is low is dropped. Reset empties the buffer and leaves every bus output at high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_addr | input | 5 | This port's bus address |
| wr_valid | input | 1 | Local write strobe |
| wr_data | input | 8 | Local write byte |
| wr_sop | input | 1 | Byte is the first of a packet |
| wr_eop | input | 1 | Byte is the last of a packet |
| wr_bad | input | 1 | Packet is bad (meaningful with wr_eop) |
| wr_ready | output | 1 | Buffer can take a byte |
| bus_addr | input | 5 | Shared poll/select address |
| bus_en | input | 1 | Shared read enable from the master |
| pkt_avail | output | 1 | Poll answer, tri-state |
| rx_data | output | 8 | Packet byte, tri-state |
| rx_valid | output | 1 | Byte valid, tri-state |
| rx_sop | output | 1 | First byte of packet, tri-state |
| rx_eop | output | 1 | Last byte of packet, tri-state |
| rx_err | output | 1 | Packet bad, with rx_eop, tri-state |

## Verification
The assertions take three things for granted about the inputs. The enable is low while reset is applied. It also drops for at least one sampled cycle between two selections. Finally, `my_addr` changes only while the port is neither selected nor polled. The stimulus respects all three. It always separates selections with idle cycles, it holds the enable low in reset, and it changes the port address only with the bus idle and pointed elsewhere. The bench puts pull-ups on the shared lines, so a released line reads as all ones.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PADDR_W = 5;
  localparam logic [PADDR_W-1:0] NULL_ADDR = '1;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sop;
    logic              eop;
    logic              bad;
  } rx_entry_t;

  // A port matches an address only if it is its own and not the null one.
  function automatic logic addr_hit(input logic [PADDR_W-1:0] seen,
                                    input logic [PADDR_W-1:0] mine);
    return (seen == mine) && (mine != NULL_ADDR);
  endfunction

  // Something is worth reporting: a whole packet end or a full block.
  function automatic logic block_ready(input int unsigned fill,
                                       input int unsigned ends,
                                       input int unsigned thresh);
    return (ends != 0) || (fill >= thresh);
  endfunction

endpackage

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import pkt_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  rx_entry_t           push_entry,
  input  logic                pop,
  output rx_entry_t           head,
  output logic [$clog2(DEPTH+1)-1:0] fill_cnt,
  output logic [$clog2(DEPTH+1)-1:0] eop_cnt,
  output logic                full,
  output logic                empty
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = mem[rd_ptr];
  assign full  = (fill_cnt == CNT_W'(DEPTH));
  assign empty = (fill_cnt == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_cnt <= '0;
      eop_cnt  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      fill_cnt <= fill_cnt + CNT_W'(push) - CNT_W'(pop);
      eop_cnt  <= eop_cnt + CNT_W'(push && push_entry.eop)
                          - CNT_W'(pop && head.eop);
    end
  end

endmodule

// File: rtl/pkt_rx_poll.sv
module pkt_rx_poll
  import pkt_rx_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned BLOCK_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PADDR_W-1:0]          bus_addr,
  input  logic [PADDR_W-1:0]          my_addr,
  input  logic [$clog2(DEPTH+1)-1:0]  fill_cnt,
  input  logic [$clog2(DEPTH+1)-1:0]  eop_cnt,
  output logic                        avail_now,
  output logic                        poll_q,
  output logic                        avail_q
);

  assign avail_now = block_ready(32'(fill_cnt), 32'(eop_cnt), BLOCK_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q  <= 1'b0;
      avail_q <= 1'b0;
    end else begin
      poll_q  <= addr_hit(bus_addr, my_addr);
      avail_q <= avail_now;
    end
  end

endmodule

// File: rtl/pkt_rx_xmit.sv
module pkt_rx_xmit
  import pkt_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic [PADDR_W-1:0] bus_addr,
  input  logic [PADDR_W-1:0] my_addr,
  input  logic               fifo_empty,
  input  rx_entry_t          head,
  output logic               pop,
  output logic               own_q,
  output logic               en_q,
  output logic               vld_q,
  output logic [BYTE_W-1:0]  data_q,
  output logic               sop_q,
  output logic               eop_q,
  output logic               err_q
);

  logic done_q;
  logic start_now;
  logic sel_now;

  // A new selection needs a fresh rise of the enable on our address.
  assign start_now = bus_en && !en_q && addr_hit(bus_addr, my_addr);
  assign sel_now   = bus_en && (own_q || start_now);
  assign pop       = sel_now && !done_q && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= 1'b0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      vld_q  <= 1'b0;
      data_q <= '0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      own_q <= sel_now;
      en_q  <= bus_en;
      if (!sel_now)                done_q <= 1'b0;
      else if (pop && head.eop)    done_q <= 1'b1;
      vld_q  <= pop;
      data_q <= pop ? head.data : '0;
      sop_q  <= pop && head.sop;
      eop_q  <= pop && head.eop;
      err_q  <= pop && head.eop && head.bad;
    end
  end

endmodule

// File: rtl/pkt_rx_port.sv
module pkt_rx_port
  import pkt_rx_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned BLOCK_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  my_addr,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        wr_sop,
  input  logic        wr_eop,
  input  logic        wr_bad,
  output logic        wr_ready,
  input  logic [4:0]  bus_addr,
  input  logic        bus_en,
  output wire         pkt_avail,
  output wire  [7:0]  rx_data,
  output wire         rx_valid,
  output wire         rx_sop,
  output wire         rx_eop,
  output wire         rx_err
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_entry_t          wr_entry;
  rx_entry_t          head;
  logic               do_push;
  logic               do_pop;
  logic               fifo_full;
  logic               fifo_empty;
  logic [CNT_W-1:0]   fill_cnt;
  logic [CNT_W-1:0]   eop_cnt;
  logic               avail_now;
  logic               poll_q;
  logic               avail_q;
  logic               drv_en;
  logic               en_q;
  logic               vld_q;
  logic [BYTE_W-1:0]  data_q;
  logic               sop_q;
  logic               eop_q;
  logic               err_q;

  assign wr_entry = '{data: wr_data, sop: wr_sop, eop: wr_eop, bad: wr_bad};
  assign do_push  = wr_valid && !fifo_full;
  assign wr_ready = !fifo_full;

  pkt_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (do_push),
    .push_entry (wr_entry),
    .pop        (do_pop),
    .head       (head),
    .fill_cnt   (fill_cnt),
    .eop_cnt    (eop_cnt),
    .full       (fifo_full),
    .empty      (fifo_empty)
  );

  pkt_rx_poll #(.DEPTH(DEPTH), .BLOCK_BYTES(BLOCK_BYTES)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .my_addr   (my_addr),
    .fill_cnt  (fill_cnt),
    .eop_cnt   (eop_cnt),
    .avail_now (avail_now),
    .poll_q    (poll_q),
    .avail_q   (avail_q)
  );

  pkt_rx_xmit u_xmit (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_addr   (bus_addr),
    .my_addr    (my_addr),
    .fifo_empty (fifo_empty),
    .head       (head),
    .pop        (do_pop),
    .own_q      (drv_en),
    .en_q       (en_q),
    .vld_q      (vld_q),
    .data_q     (data_q),
    .sop_q      (sop_q),
    .eop_q      (eop_q),
    .err_q      (err_q)
  );

  // Shared lines: driven only while this port answers or owns the bus.
  assign pkt_avail = poll_q ? avail_q : 1'bz;
  assign rx_valid  = drv_en ? vld_q   : 1'bz;
  assign rx_data   = drv_en ? data_q  : 8'bz;
  assign rx_sop    = drv_en ? sop_q   : 1'bz;
  assign rx_eop    = drv_en ? eop_q   : 1'bz;
  assign rx_err    = drv_en ? err_q   : 1'bz;

endmodule

// File: rtl/pkt_rx_port_chk.sv
module pkt_rx_port_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_en,
  input logic [4:0]                 bus_addr,
  input logic [4:0]                 my_addr,
  input logic                       drv_en,
  input logic                       en_q,
  input logic                       poll_q,
  input logic                       vld_q,
  input logic                       sop_q,
  input logic                       eop_q,
  input logic                       err_q,
  input logic [$clog2(DEPTH+1)-1:0] fill_cnt
);

  // R4
  sel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !en_q && bus_addr == my_addr && my_addr != 5'h1F) |=> drv_en);

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && bus_en) |=> drv_en);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !drv_en);

  // R3
  null_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (my_addr == 5'h1F && !drv_en) |=> (!poll_q && !drv_en));

  // R7
  err_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (eop_q && vld_q));

  // R5
  sop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && sop_q) |=> !sop_q);

  // R6
  end_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && eop_q) |=> !vld_q);

  // R10
  always_comb begin
    if (rst_n) begin
      no_overflow_chk: assert (32'(fill_cnt) <= DEPTH);
    end
  end

endmodule

bind pkt_rx_port pkt_rx_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_addr (bus_addr),
  .my_addr  (my_addr),
  .drv_en   (drv_en),
  .en_q     (en_q),
  .poll_q   (poll_q),
  .vld_q    (vld_q),
  .sop_q    (sop_q),
  .eop_q    (eop_q),
  .err_q    (err_q),
  .fill_cnt (fill_cnt)
);

// File: tb/pkt_rx_port_tb_top.sv
`timescale 1ns/1ps
module pkt_rx_port_tb_top;

  localparam int DEPTH = 16;
  localparam int BLOCK = 8;
  localparam int WD_LIMIT = 5000;

  typedef struct packed {
    logic [7:0] d;
    logic       s;
    logic       e;
    logic       b;
  } ent_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] my_addr = 5'd3;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_sop = 1'b0;
  logic       wr_eop = 1'b0;
  logic       wr_bad = 1'b0;
  logic       wr_ready;
  logic [4:0] bus_addr = 5'd9;
  logic       bus_en = 1'b0;
  wire        pkt_avail;
  wire  [7:0] rx_data;
  wire        rx_valid;
  wire        rx_sop;
  wire        rx_eop;
  wire        rx_err;

  pullup pu_av (pkt_avail);
  pullup pu_v  (rx_valid);
  pullup pu_s  (rx_sop);
  pullup pu_e  (rx_eop);
  pullup pu_r  (rx_err);
  for (genvar gi = 0; gi < 8; gi++) begin : g_pu
    pullup pu_d (rx_data[gi]);
  end

  pkt_rx_port #(.DEPTH(DEPTH), .BLOCK_BYTES(BLOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .my_addr(my_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .wr_bad(wr_bad), .wr_ready(wr_ready),
    .bus_addr(bus_addr), .bus_en(bus_en), .pkt_avail(pkt_avail),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_err(rx_err)
  );

  always #2 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_tag = "R10";

  // Behavioural reference model
  ent_t       mq[$];
  bit         m_own = 0, m_enq = 0, m_done = 0;
  bit         m_vld = 0, m_sop = 0, m_eop = 0, m_err = 0;
  bit [7:0]   m_data = 0;
  bit         m_poll = 0, m_avail = 0;

  always @(posedge clk or negedge rst_n) begin : model
    int   ends;
    bit   hit, req, canpush;
    ent_t e;
    if (!rst_n) begin
      mq.delete();
      m_own = 0; m_enq = 0; m_done = 0;
      m_vld = 0; m_sop = 0; m_eop = 0; m_err = 0; m_data = 0;
      m_poll = 0; m_avail = 0;
    end else begin
      ends = 0;
      foreach (mq[k]) if (mq[k].e) ends++;
      hit     = (bus_addr == my_addr) && (my_addr != 5'd31);
      req     = bus_en && (m_own || (!m_enq && hit));
      canpush = mq.size() < DEPTH;
      m_poll  = hit;
      m_avail = (ends > 0) || (mq.size() >= BLOCK);
      if (req && !m_done && mq.size() > 0) begin
        e = mq.pop_front();
        m_vld = 1; m_data = e.d; m_sop = e.s; m_eop = e.e; m_err = e.e && e.b;
        m_done = e.e;
      end else begin
        m_vld = 0; m_data = 0; m_sop = 0; m_eop = 0; m_err = 0;
      end
      if (!req) m_done = 0;
      m_own = req;
      m_enq = bus_en;
      if (wr_valid && canpush) mq.push_back('{wr_data, wr_sop, wr_eop, wr_bad});
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin : compare
    logic [11:0] act_bus, exp_bus;
    if (!done) begin
      act_bus = {rx_valid, rx_data, rx_sop, rx_eop, rx_err};
      exp_bus = m_own ? {m_vld, m_data, m_sop, m_eop, m_err} : 12'hFFF;
      check(act_bus === exp_bus, m_own ? cur_tag : "R8", "bus", act_bus, exp_bus);
      check(pkt_avail === (m_poll ? m_avail : 1'b1), cur_tag, "avail",
            {11'd0, pkt_avail}, {11'd0, (m_poll ? m_avail : 1'b1)});
      check(wr_ready === (mq.size() < DEPTH), "R10", "ready",
            {11'd0, wr_ready}, {11'd0, (mq.size() < DEPTH)});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  task automatic step(input logic en, input logic [4:0] a,
                      input logic wv = 0, input logic [7:0] d = 0,
                      input logic s = 0, input logic e = 0, input logic b = 0);
    bus_en = en; bus_addr = a;
    wr_valid = wv; wr_data = d; wr_sop = s; wr_eop = e; wr_bad = b;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e, input logic b);
    step(1'b0, 5'd9, 1'b1, d, s, e, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 5'd9);
  endtask

  initial begin
    @(negedge clk);
    // R10: reset state is released and empty
    cur_tag = "R10";
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1: polls of own address with empty buffer, and of another address
    cur_tag = "R1";
    step(0, 5'd3); step(0, 5'd7); step(0, 5'd3); idle(2);

    // R2: end tag makes the packet available
    cur_tag = "R2";
    for (int i = 0; i < 4; i++) put(8'hA0 + 8'(i), i == 0, i == 3, 1'b0);
    step(0, 5'd3); idle(2);

    // R4 R5 R6: one whole packet, idle driven cycles after the end
    cur_tag = "R4 R5 R6";
    for (int i = 0; i < 8; i++) step(1, 5'd3);
    cur_tag = "R8";
    idle(2);

    // R2: threshold of buffered bytes without an end
    cur_tag = "R2";
    for (int i = 0; i < 5; i++) put(8'hB0 + 8'(i), i == 0, 1'b0, 1'b0);
    step(0, 5'd3); idle(1);
    for (int i = 5; i < 10; i++) put(8'hB0 + 8'(i), 1'b0, 1'b0, 1'b0);
    step(0, 5'd3); idle(1);

    // R9: enable withdrawn mid-packet, then resumed
    cur_tag = "R9";
    for (int i = 0; i < 4; i++) step(1, 5'd3);
    idle(2);
    for (int i = 0; i < 3; i++) step(1, 5'd3);
    idle(2);

    // R7: bad end byte drives the error line
    cur_tag = "R7";
    put(8'h5A, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1, 5'd3);
    idle(2);

    // R3: null address never matches
    cur_tag = "R3";
    my_addr = 5'd31;
    put(8'hC0, 1'b1, 1'b0, 1'b0);
    put(8'hC1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1, 5'd31);
    step(0, 5'd31); step(0, 5'd31); idle(1);
    my_addr = 5'd3;
    idle(1);
    cur_tag = "R4 R5 R6";
    for (int i = 0; i < 4; i++) step(1, 5'd3);
    idle(2);

    // R1 R8: polls answered while another port owns the bus
    cur_tag = "R1 R8";
    put(8'hD0, 1'b1, 1'b0, 1'b0);
    put(8'hD1, 1'b0, 1'b1, 1'b0);
    step(1, 5'd12);
    for (int i = 0; i < 3; i++) step(1, 5'd3);
    idle(2);
    for (int i = 0; i < 4; i++) step(1, 5'd3);
    idle(2);

    // R10: overflow drops writes, then drain
    cur_tag = "R10";
    for (int i = 0; i < 20; i++) put(8'(i), i == 0, i == 15, 1'b0);
    idle(1);
    cur_tag = "R5 R6";
    for (int i = 0; i < 20; i++) step(1, 5'd3);
    idle(2);

    // R6: two packets buffered, one per selection
    cur_tag = "R6";
    put(8'hE0, 1'b1, 1'b0, 1'b0);
    put(8'hE1, 1'b0, 1'b1, 1'b0);
    put(8'hF0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1, 5'd3);
    idle(1);
    for (int i = 0; i < 3; i++) step(1, 5'd3);
    idle(2);

    // R10: reset in the middle empties the buffer
    cur_tag = "R10";
    put(8'h77, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    step(0, 5'd3); idle(2);

    finish_run();
  end

endmodule